// File: doc/BRIEF.md
# JTAG TAP Shift Engine

This block is a JTAG master that shifts one field of 1 to 32 bits through a target's instruction register or a data register. It produces TCK from the system clock with a programmable divider, drives TMS and TDI, and samples TDO. A request carries the data word, the bit count and a set of flags. The flags select the register, the bit order, whether the scan stays open for more bits, and whether the walk stops in Update or goes back to Run-Test/Idle. A request can also ask for a TAP reset instead of a shift.

The engine remembers where it left the TAP controller, in a 3-bit position register. The next request uses it to pick the shortest TMS walk into Shift-DR or Shift-IR. A long scan can therefore be built from several requests, for example 32 + 5 + 1 bits, without leaving Shift-DR. A typical bring-up sequence is a TAP reset followed by a 32-bit data read, which returns the identification word.

Requests use a valid/ready handshake. `req_ready` is high only while the engine is idle, and one request is taken per handshake. The response has no back-pressure. `rsp_valid` is high for one cycle with the captured bits, and the consumer must take them in that cycle.

Top module: `jtag_shift_engine`

## Requirements
- R1: While reset is applied and after it is released, `tck`, `tms` and `tdi` are 0, `req_ready` is 1, `rsp_valid` is 0 and `tap_state` reads the Reset code.
- R2: A request is taken on a clock edge where both `req_valid` and `req_ready` are 1. From the next cycle `req_ready` stays 0 until the cycle in which `rsp_valid` pulses high for exactly one cycle with `rsp_data`. `req_ready` is 1 again in that same cycle.
- R3: Each TCK half period lasts `clk_div`+1 system clocks. TMS and TDI change only while TCK is low, and TDO is sampled at the moment TCK rises.
- R4: A request with `req_tap_reset`=1 produces exactly five TCK cycles with TMS=1 and leaves `tap_state` at Reset. The other fields are not used and `rsp_data` is 0.
- R5: A request with `req_ir`=1 shifts through Shift-IR. A request with `req_ir`=0 shifts through Shift-DR.
- R6: With `req_no_idle`=0 and no chaining, the walk leaves Shift on the last bit with TMS=1, passes Exit1 and Update, and ends in Run-Test/Idle.
- R7: With `req_no_idle`=1, the walk ends in Update-DR or Update-IR and the TAP never enters Run-Test/Idle during that request.
- R8: A data-register request with `req_chain`=1 holds TMS=0 on its last bit and leaves the TAP in Shift-DR. The next data-register request appends bits to the same scan with no TCK cycles before its first data bit. `req_chain` is ignored for instruction-register requests.
- R9: With `req_msb_first`=0, bit 0 of `req_data` is sent first, and the k-th bit captured is returned in bit k. With `req_msb_first`=1, bit `req_len`-1 is sent first, and the k-th bit captured is returned in bit `req_len`-1-k. Bits of `rsp_data` at and above `req_len` are 0.
- R10: Any `req_len` from 1 to 32 is accepted, and lengths of 1, 4, 5, 9 and 32 may be mixed within one scan.
- R11: The number of TCK cycles before the first data bit is 3 for a DR request and 4 for an IR request when starting from Run-Test/Idle or an Update state. Each count is one more when starting from Reset. It is 0 for a DR request and 6 for an IR request when starting from Shift-DR. Afterwards the walk takes 2 TCK cycles to reach Run-Test/Idle, 1 to stop in Update, and 0 when chained.
- R12: `tap_state` encodes Reset=0, Run-Test/Idle=1, Shift-DR=2, Update-DR=3 and Update-IR=4, and is updated in the cycle that `rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_div | input | DIV_W | TCK half period minus one, in system clocks |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_data | input | DATA_W | Bits to shift out |
| req_len | input | LEN_W | Field length, 1 to DATA_W |
| req_ir | input | 1 | 1 selects the instruction register, 0 a data register |
| req_msb_first | input | 1 | 1 sends and returns the most significant bit first |
| req_no_idle | input | 1 | 1 stops in Update instead of Run-Test/Idle |
| req_chain | input | 1 | 1 stays in Shift-DR after a DR field |
| req_tap_reset | input | 1 | 1 makes the request a TAP reset |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_data | output | DATA_W | Captured TDO bits |
| tap_state | output | 3 | Position the TAP was left in |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the target |
| tdo | input | 1 | Test data from the target |

## Verification
The bench connects the engine to a behavioural 16-state TAP target that has an identification register and a 64-bit scan register. Fresh captures from Reset, Idle and Update positions test whether the entry walk is chosen correctly. Chained DR fields of 5, 9 and 4 bits test whether a scan continues or is restarted, because a restarted scan returns the capture pattern from its start again. Mixing LSB-first and MSB-first fields checks both directions of the bit ordering. After each update, the register contents show the order in which TDI was driven. Requests with Update endings and an IR request made from inside Shift-DR cover the stop-in-Update paths and the exit-and-reenter path. Two divider settings check the length of the TCK half period.

// File: rtl/jtag_shift_pkg.sv
package jtag_shift_pkg;

  // Where the engine leaves the TAP controller between requests
  typedef enum logic [2:0] {
    TP_RESET    = 3'd0,
    TP_IDLE     = 3'd1,
    TP_SHIFT_DR = 3'd2,
    TP_UPD_DR   = 3'd3,
    TP_UPD_IR   = 3'd4
  } tap_pos_e;

  // Segments of one request's TCK sequence
  typedef enum logic [1:0] {
    PH_PRE   = 2'd0,
    PH_SHIFT = 2'd1,
    PH_POST  = 2'd2,
    PH_END   = 2'd3
  } seq_phase_e;

  localparam int PRE_W     = 8;  // longest entry walk is 6 cycles
  localparam int PRE_LEN_W = 4;
  localparam int POST_W    = 2;

endpackage

// File: rtl/jtag_tck_gen.sv
module jtag_tck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || cnt_q == div) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == div);

endmodule

// File: rtl/jtag_path_plan.sv
module jtag_path_plan
  import jtag_shift_pkg::*;
(
  input  tap_pos_e               cur_pos,
  input  logic                   ir,
  input  logic                   chain,
  input  logic                   no_idle,
  input  logic                   tap_reset,
  output logic [PRE_W-1:0]       pre_tms,
  output logic [PRE_LEN_W-1:0]   pre_len,
  output logic [POST_W-1:0]      post_tms,
  output logic [1:0]             post_len,
  output logic                   last_tms,
  output tap_pos_e               end_pos
);

  logic chained;

  assign chained = !tap_reset && !ir && chain;

  // Entry walk, first TMS bit in bit 0
  always_comb begin
    pre_tms = '0;
    pre_len = '0;
    if (tap_reset) begin
      pre_tms = 8'b0001_1111;
      pre_len = 4'd5;
    end else begin
      unique case (cur_pos)
        TP_SHIFT_DR: begin
          // exit through Update-DR, then Select-DR, Select-IR, Capture, Shift
          pre_tms = ir ? 8'b0000_1111 : 8'b0;
          pre_len = ir ? 4'd6 : 4'd0;
        end
        TP_RESET: begin
          pre_tms = ir ? 8'b0000_0110 : 8'b0000_0010;
          pre_len = ir ? 4'd5 : 4'd4;
        end
        default: begin
          pre_tms = ir ? 8'b0000_0011 : 8'b0000_0001;
          pre_len = ir ? 4'd4 : 4'd3;
        end
      endcase
    end
  end

  // Exit walk: Exit1 -> Update (TMS 1), then optionally Update -> Idle (TMS 0)
  always_comb begin
    post_tms = 2'b01;
    last_tms = !chained;
    if (tap_reset || chained) begin
      post_len = 2'd0;
    end else if (no_idle) begin
      post_len = 2'd1;
    end else begin
      post_len = 2'd2;
    end
    if (tap_reset) begin
      end_pos = TP_RESET;
    end else if (chained) begin
      end_pos = TP_SHIFT_DR;
    end else if (no_idle) begin
      end_pos = ir ? TP_UPD_IR : TP_UPD_DR;
    end else begin
      end_pos = TP_IDLE;
    end
  end

endmodule

// File: rtl/jtag_field_order.sv
module jtag_field_order #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic [DATA_W-1:0] data,
  input  logic [LEN_W-1:0]  len,
  input  logic              msb_first,
  output logic [DATA_W-1:0] word
);

  localparam int IDX_W = $clog2(DATA_W);

  // word[0] is always the first bit on TDI
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic [LEN_W:0] src;
    logic           in_field;
    assign src      = {1'b0, len} - (LEN_W+1)'(i + 1);
    assign in_field = (LEN_W+1)'(i) < {1'b0, len};
    assign word[i]  = !msb_first ? data[i]
                    : (in_field ? data[src[IDX_W-1:0]] : 1'b0);
  end

endmodule

// File: rtl/jtag_shift_engine.sv
module jtag_shift_engine
  import jtag_shift_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int DIV_W  = 8,
  localparam int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_data,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_ir,
  input  logic              req_msb_first,
  input  logic              req_no_idle,
  input  logic              req_chain,
  input  logic              req_tap_reset,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [2:0]        tap_state,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  input  logic              tdo
);

  tap_pos_e             pos_q, end_q, p_end;
  seq_phase_e           ph_q, first_ph, after_pre, after_shift;
  logic                 busy_q, fresh_q, msb_q, last_tms_q;
  logic [LEN_W-1:0]     cnt_q, len_q, limit, eff_len;
  logic [PRE_W-1:0]     pre_q, p_pre;
  logic [PRE_LEN_W-1:0] pre_len_q, p_pre_len;
  logic [POST_W-1:0]    post_q, p_post;
  logic [1:0]           post_len_q, p_post_len;
  logic                 p_last_tms;
  logic [DATA_W-1:0]    sh_q, cap_q, ordered, aligned;
  logic                 tck_q, tms_q, tdi_q, rsp_valid_q;
  logic [DATA_W-1:0]    rsp_data_q;
  logic                 tick, take, cur_tms, cur_tdi;

  assign take = req_valid && !busy_q;

  jtag_tck_gen #(.DIV_W(DIV_W)) u_tck_gen (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_q),
    .div  (clk_div),
    .tick (tick)
  );

  jtag_path_plan u_plan (
    .cur_pos  (pos_q),
    .ir       (req_ir),
    .chain    (req_chain),
    .no_idle  (req_no_idle),
    .tap_reset(req_tap_reset),
    .pre_tms  (p_pre),
    .pre_len  (p_pre_len),
    .post_tms (p_post),
    .post_len (p_post_len),
    .last_tms (p_last_tms),
    .end_pos  (p_end)
  );

  jtag_field_order #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_order (
    .data     (req_data),
    .len      (req_len),
    .msb_first(req_msb_first),
    .word     (ordered)
  );

  assign eff_len  = req_tap_reset ? '0 : req_len;
  assign first_ph = (p_pre_len != '0) ? PH_PRE
                  : (eff_len != '0)   ? PH_SHIFT
                  : (p_post_len != '0) ? PH_POST : PH_END;
  assign after_shift = (post_len_q != '0) ? PH_POST : PH_END;
  assign after_pre   = (len_q != '0) ? PH_SHIFT : after_shift;
  assign aligned     = msb_q ? cap_q : (cap_q >> (LEN_W'(DATA_W) - len_q));

  // Current TCK item of the sequence
  always_comb begin
    cur_tms = 1'b0;
    cur_tdi = 1'b0;
    limit   = '0;
    unique case (ph_q)
      PH_PRE: begin
        cur_tms = pre_q[cnt_q[2:0]];
        limit   = LEN_W'(pre_len_q);
      end
      PH_SHIFT: begin
        cur_tdi = sh_q[0];
        cur_tms = (cnt_q == len_q - 1'b1) ? last_tms_q : 1'b0;
        limit   = len_q;
      end
      PH_POST: begin
        cur_tms = post_q[cnt_q[0]];
        limit   = LEN_W'(post_len_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q       <= TP_RESET;
      end_q       <= TP_RESET;
      ph_q        <= PH_END;
      busy_q      <= 1'b0;
      fresh_q     <= 1'b0;
      msb_q       <= 1'b0;
      last_tms_q  <= 1'b0;
      cnt_q       <= '0;
      len_q       <= '0;
      pre_q       <= '0;
      pre_len_q   <= '0;
      post_q      <= '0;
      post_len_q  <= '0;
      sh_q        <= '0;
      cap_q       <= '0;
      tck_q       <= 1'b0;
      tms_q       <= 1'b0;
      tdi_q       <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (take) begin
        busy_q     <= 1'b1;
        fresh_q    <= 1'b1;
        ph_q       <= first_ph;
        cnt_q      <= '0;
        len_q      <= eff_len;
        msb_q      <= req_msb_first;
        pre_q      <= p_pre;
        pre_len_q  <= p_pre_len;
        post_q     <= p_post;
        post_len_q <= p_post_len;
        last_tms_q <= p_last_tms;
        end_q      <= p_end;
        sh_q       <= ordered;
        cap_q      <= '0;
      end else if (busy_q && tick) begin
        if (!tck_q) begin
          if (fresh_q) begin
            fresh_q <= 1'b0;
            tms_q   <= cur_tms;
            tdi_q   <= cur_tdi;
          end else begin
            tck_q <= 1'b1;
            if (ph_q == PH_SHIFT) begin
              sh_q  <= sh_q >> 1;
              cap_q <= msb_q ? {cap_q[DATA_W-2:0], tdo} : {tdo, cap_q[DATA_W-1:1]};
            end
            if (cnt_q + 1'b1 == limit) begin
              cnt_q <= '0;
              ph_q  <= (ph_q == PH_PRE) ? after_pre
                     : (ph_q == PH_SHIFT) ? after_shift : PH_END;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end else begin
          tck_q <= 1'b0;
          if (ph_q == PH_END) begin
            busy_q      <= 1'b0;
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= aligned;
            pos_q       <= end_q;
            tdi_q       <= 1'b0;
          end else begin
            tms_q <= cur_tms;
            tdi_q <= cur_tdi;
          end
        end
      end
    end
  end

  assign req_ready = !busy_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign tap_state = pos_q;
  assign tck       = tck_q;
  assign tms       = tms_q;
  assign tdi       = tdi_q;

  // R3: pins only move while TCK is low
  a_r3_pins_stable_tck_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi)));

  // R2: done lasts one cycle and comes with the engine free again
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r2_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  // R1: TCK parks low whenever the engine is idle
  a_r1_tck_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !tck);

  // R12: only the five position codes appear, and they change only with done
  a_r12_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    tap_state <= 3'd4);
  a_r12_state_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(tap_state));

  // R8: a chained field finishes with TMS low so Shift-DR is held
  a_r8_chain_holds_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && tap_state == TP_SHIFT_DR) |-> !tms);

  // R7: an Update ending leaves TMS high, so no step into Idle was taken
  a_r7_update_end_tms_high: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (tap_state == TP_UPD_DR || tap_state == TP_UPD_IR)) |-> tms);

  // R10: shift requests carry a legal length
  a_r10_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_tap_reset) |-> (req_len != '0 && req_len <= LEN_W'(DATA_W)));

endmodule

// File: tb/jtag_shift_engine_tb_top.sv
module jtag_shift_engine_tb_top;
  import jtag_shift_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IDC   = 32'h4F1F_0A6B;
  localparam logic [63:0] CAP64 = 64'hA5C3_1E96_7B28_D04F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  clk_div = 8'd1;
  logic        req_valid = 1'b0, req_ir = 1'b0, req_msb_first = 1'b0;
  logic        req_no_idle = 1'b0, req_chain = 1'b0, req_tap_reset = 1'b0;
  logic [31:0] req_data = '0;
  logic [5:0]  req_len = '0;
  logic        req_ready, rsp_valid, tck, tms, tdi;
  logic        tdo = 1'b0;
  logic [31:0] rsp_data;
  logic [2:0]  tap_state;

  int vecs = 0;
  int errs = 0;
  int cyc  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_shift_engine dut_i (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
    .req_len(req_len), .req_ir(req_ir), .req_msb_first(req_msb_first),
    .req_no_idle(req_no_idle), .req_chain(req_chain), .req_tap_reset(req_tap_reset),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .tap_state(tap_state),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  // ---------------- behavioural target TAP ----------------
  typedef enum int {TLR, RTI, SDS, CDR, SHDR, E1DR, PDR, E2DR, UDR,
                    SIS, CIR, SHIR, E1IR, PIR, E2IR, UIR} tgt_st_e;
  tgt_st_e     st = TLR;
  logic [3:0]  t_ir = 4'hE, t_irsh = 4'h0;
  logic [31:0] t_id = '0;
  logic [63:0] t_sc = '0, t_upd = '0;
  int          rises = 0, idle_entries = 0;

  always @(posedge tck) begin
    tgt_st_e nx;
    rises++;
    case (st)
      CDR:  if (t_ir == 4'hE) t_id <= IDC; else t_sc <= CAP64;
      SHDR: if (t_ir == 4'hE) t_id <= {tdi, t_id[31:1]}; else t_sc <= {tdi, t_sc[63:1]};
      CIR:  t_irsh <= 4'b0001;
      SHIR: t_irsh <= {tdi, t_irsh[3:1]};
      default: ;
    endcase
    case (st)
      TLR:  nx = tms ? TLR  : RTI;
      RTI:  nx = tms ? SDS  : RTI;
      SDS:  nx = tms ? SIS  : CDR;
      CDR:  nx = tms ? E1DR : SHDR;
      SHDR: nx = tms ? E1DR : SHDR;
      E1DR: nx = tms ? UDR  : PDR;
      PDR:  nx = tms ? E2DR : PDR;
      E2DR: nx = tms ? UDR  : SHDR;
      UDR:  nx = tms ? SDS  : RTI;
      SIS:  nx = tms ? TLR  : CIR;
      CIR:  nx = tms ? E1IR : SHIR;
      SHIR: nx = tms ? E1IR : SHIR;
      E1IR: nx = tms ? UIR  : PIR;
      PIR:  nx = tms ? E2IR : PIR;
      E2IR: nx = tms ? UIR  : SHIR;
      default: nx = tms ? SDS : RTI;
    endcase
    if (nx == RTI) idle_entries++;
    st <= nx;
  end

  always @(negedge tck) begin
    if (st == UDR && t_ir != 4'hE) t_upd <= t_sc;
    if (st == UIR) t_ir <= t_irsh;
    if (st == TLR) t_ir <= 4'hE;
    if (st == SHDR)      tdo <= (t_ir == 4'hE) ? t_id[0] : t_sc[0];
    else if (st == SHIR) tdo <= t_irsh[0];
    else                 tdo <= 1'b0;
  end

  function automatic logic [2:0] tgt_code(tgt_st_e s);
    case (s)
      TLR: return 3'd0;  RTI: return 3'd1;  SHDR: return 3'd2;
      UDR: return 3'd3;  UIR: return 3'd4;  default: return 3'd7;
    endcase
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R3: every clock, TCK high time and pin stability while TCK is high
  int   hi_run = 0;
  logic p_tck = 1'b0, p_tms = 1'b0, p_tdi = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tck) begin
        hi_run++;
        if (p_tck) chk("R3 pins stable while tck high", {tms, tdi}, {p_tms, p_tdi});
      end else if (hi_run > 0) begin
        chk("R3 tck high half period", 64'(hi_run), 64'(clk_div) + 64'd1);
        hi_run = 0;
      end
      p_tck = tck; p_tms = tms; p_tdi = tdi;
    end
  end

  task automatic summary_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      summary_and_end();
    end
  end

  // ---------------- reference model state ----------------
  logic [2:0] m_pos = 3'd0;
  logic [3:0] m_ir  = 4'hE;
  bit         q[$];

  task automatic run_req(input logic rst, input logic ir, input logic [31:0] data,
                         input int len, input logic msb, input logic noidle,
                         input logic chain, input string tag);
    int pre, post, tot, r0, i0, w;
    logic chained;
    logic [31:0] exp;
    logic [63:0] qv;
    chained = !rst && !ir && chain;
    if (rst) pre = 5;
    else if (m_pos == 3'd2) pre = ir ? 6 : 0;
    else if (m_pos == 3'd0) pre = ir ? 5 : 4;
    else pre = ir ? 4 : 3;
    post = (rst || chained) ? 0 : (noidle ? 1 : 2);
    tot  = pre + (rst ? 0 : len) + post;
    exp  = '0;
    if (rst) begin
      exp = '0;
    end else if (ir) begin
      exp = 32'h1;
    end else if (m_ir == 4'hE) begin
      exp = IDC;
    end else begin
      if (pre > 0) begin
        q = {};
        for (int i = 0; i < 64; i++) q.push_back(CAP64[i]);
      end
      for (int k = 0; k < len; k++) begin
        int idx;
        idx = msb ? (len - 1 - k) : k;
        exp[idx] = q.pop_front();
        q.push_back(data[idx]);
      end
    end
    r0 = rises;
    i0 = idle_entries;
    @(negedge clk);
    req_tap_reset = rst; req_ir = ir; req_data = data; req_len = 6'(len);
    req_msb_first = msb; req_no_idle = noidle; req_chain = chain;
    chk({tag, " R2 ready before request"}, 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R2 ready low while busy"}, 64'(req_ready), 64'd0);
    w = 0;
    while (!rsp_valid && w < 20000) begin
      @(negedge clk);
      w++;
    end
    chk({tag, " R2 done seen"}, 64'(rsp_valid), 64'd1);
    chk({tag, " R9 R10 captured data"}, 64'(rsp_data), 64'(exp));
    chk({tag, " R11 tck cycle count"}, 64'(rises - r0), 64'(tot));
    if (rst) m_pos = 3'd0;
    else if (chained) m_pos = 3'd2;
    else if (noidle) m_pos = ir ? 3'd4 : 3'd3;
    else m_pos = 3'd1;
    chk({tag, " R12 tap_state"}, 64'(tap_state), 64'(m_pos));
    chk({tag, " R5 R6 target position"}, 64'(tgt_code(st)), 64'(m_pos));
    if (noidle && !rst) chk({tag, " R7 no idle entered"}, 64'(idle_entries - i0), 64'd0);
    @(negedge clk);
    chk({tag, " R2 done one cycle"}, 64'(rsp_valid), 64'd0);
    chk({tag, " R2 ready after done"}, 64'(req_ready), 64'd1);
    if (rst) m_ir = 4'hE;
    else if (ir) m_ir = data[3:0];
    if (!rst && !ir && !chained && m_ir != 4'hE) begin
      for (int i = 0; i < 64; i++) qv[i] = q[i];
      chk({tag, " R9 tdi order in target register"}, t_upd, qv);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values at the ports
    chk("R1 pins in reset", {tck, tms, tdi, rsp_valid}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 64'(req_ready), 64'd1);
    chk("R1 R12 state after reset", 64'(tap_state), 64'd0);
    chk("R1 pins after reset", {tck, tms, tdi}, 3'b0);

    run_req(1, 0, 32'hFFFF_FFFF, 7, 1, 1, 1, "T1 R4 tap reset");
    run_req(0, 0, 32'h0, 32, 0, 0, 0, "T2 R6 idcode read from reset");
    run_req(0, 1, 32'h8, 4, 0, 1, 0, "T3 R5 R7 ir to update");
    run_req(0, 0, 32'h15, 5, 0, 0, 1, "T4 R8 chain 5 lsb");
    run_req(0, 0, 32'h1A5, 9, 1, 0, 1, "T5 R8 R9 chain 9 msb");
    clk_div = 8'd3;
    run_req(0, 0, 32'h1, 1, 0, 1, 0, "T6 R7 R10 one bit to update");
    run_req(0, 0, 32'hC3A5_0F1E, 32, 1, 0, 0, "T7 R9 32 msb");
    run_req(0, 0, 32'hA, 4, 0, 0, 1, "T8 R8 chain from idle");
    run_req(0, 1, 32'hE, 4, 0, 0, 1, "T9 R8 R11 ir from shift-dr");
    clk_div = 8'd0;
    run_req(0, 0, 32'h0, 32, 0, 0, 0, "T10 R3 idcode fast tck");
    run_req(1, 0, 32'h0, 1, 0, 0, 0, "T11 R4 reset from idle");

    repeat (4) @(negedge clk);
    summary_and_end();
  end

endmodule